// File: doc/BRIEF.md
# DRAM DLL-Disable Transition Sequencer

This block sits in a memory controller and walks a DDR3-style DRAM from DLL-enabled to DLL-disabled operation. A start request is taken only when the controller reports the device idle: all banks precharged, all timings met and termination in high impedance. The sequencer then drives a fixed series of commands on a small command/bank/address output, with NOP on every cycle in between. It first writes MR1 with the DLL-disable bit set. It enters self-refresh and asks an external clock agent to change the input clock frequency. It then leaves self-refresh and writes MR0 and MR2 with settings chosen for DLL-off operation. Finally it reports done.

Every wait is a down-counter. The counter loads from a run-time cycle value (tMOD, tCKSRE, tCKSRX, tXS) when the preceding event happens. The state machine moves on in the cycle after the counter reads zero. The block owns CKE and ODT while a sequence runs. CKE is low while the device is in self-refresh. ODT is held low from the MR1 write up to done. The one exception is the post-exit stretch when both termination features were disabled at self-refresh entry: ODT then follows the controller's own ODT request. A start that arrives at the wrong time is dropped and flagged.

Top module: `dlloff_seq`

## Requirements
- R1: Out of reset the outputs are cmd_o NOP, cke_o 1, busy_o 0, done_o 0, err_o 0 and clk_chg_req_o 0.
- R2: A start_i sampled while the block is idle and idle_i is 1 begins a sequence. In the next cycle the block issues MRS (cmd_o code 1) with ba_o 1 and addr_o equal to mr1_val_i with bit 0 forced to 1.
- R3: Command codes are NOP 0, MRS 1, SRE 2 and SRX 3. Every cycle of a sequence that carries no explicit command drives NOP.
- R4: SRE is issued t_mod_i+2 cycles after the MR1 write, so a value of 0 gives a gap of 2 cycles.
- R5: clk_chg_req_o rises t_cksre_i+2 cycles after SRE. It stays high until clk_chg_ack_i is sampled high, with no upper limit on the stall.
- R6: SRX is issued t_cksrx_i+2 cycles after the last cycle in which clk_chg_req_o is high.
- R7: cke_o is low from the SRE cycle up to the cycle before SRX, and high in every other cycle.
- R8: From the MR1 write until SRX, odt_o is 0. From SRX through done, odt_o is 0 if term_nom_en_i or term_wr_en_i was 1 in the SRE cycle; otherwise it follows odt_i. Changes to the enables after SRE have no effect. While idle, odt_o follows odt_i.
- R9: t_xs_i+2 cycles after SRX the block writes MR0 (MRS, ba_o 0, addr_o = mr0_val_i). t_mod_i+2 cycles later it writes MR2 (MRS, ba_o 2, addr_o = mr2_val_i).
- R10: done_o pulses for one cycle t_mod_i+2 cycles after the MR2 write. busy_o is low in the next cycle.
- R11: A start_i sampled while busy_o is 1 or idle_i is 0 is ignored: the command stream and busy_o are unchanged. err_o is 1 for one cycle, in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the DLL-off sequence |
| idle_i | input | 1 | Device idle, timings met, termination high impedance |
| t_mod_i | input | CNT_W | tMOD wait in cycles |
| t_cksre_i | input | CNT_W | tCKSRE wait in cycles |
| t_cksrx_i | input | CNT_W | tCKSRX wait in cycles |
| t_xs_i | input | CNT_W | tXS wait in cycles |
| term_nom_en_i | input | 1 | Nominal termination enabled in mode registers |
| term_wr_en_i | input | 1 | Write termination enabled in mode registers |
| odt_i | input | 1 | Controller's own ODT request |
| mr1_val_i | input | ADDR_W | MR1 contents (bit 0 forced to 1) |
| mr0_val_i | input | ADDR_W | MR0 contents for DLL-off operation |
| mr2_val_i | input | ADDR_W | MR2 contents for DLL-off operation |
| clk_chg_ack_i | input | 1 | Clock agent finished the frequency change |
| clk_chg_req_o | output | 1 | Request to change the input clock |
| cmd_o | output | 2 | Command code |
| ba_o | output | BA_W | Bank address (mode register select) |
| addr_o | output | ADDR_W | Address bus |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle ready pulse |
| err_o | output | 1 | Start request rejected |

## Verification
Every output decodes the state register directly, so a wrong state shows at the ports in the very cycle it is entered. It can show as a command in the wrong cycle, a CKE or ODT level that does not match the phase, or a clock request that drops early. The bench checks each of these on every cycle of each sequence, so a gap that is off by one is caught on its first cycle. Errors in the termination latch appear only after self-refresh exit. The bench therefore flips the enables once SRE has passed.

// File: rtl/dlloff_pkg.sv
package dlloff_pkg;
   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_MRS = 2'd1,
      CMD_SRE = 2'd2,
      CMD_SRX = 2'd3
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_MR1, ST_W1, ST_SRE, ST_WSRE, ST_CREQ, ST_WSRX,
      ST_SRX, ST_WXS, ST_MR0, ST_W2, ST_MR2, ST_W3, ST_DONE
   } state_e;

   localparam int unsigned MR0_SEL = 0;
   localparam int unsigned MR1_SEL = 1;
   localparam int unsigned MR2_SEL = 2;
endpackage

// File: rtl/dlloff_wait_ctr.sv
module dlloff_wait_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dlloff_fsm.sv
module dlloff_fsm
   import dlloff_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             idle_i,
   input  logic             ack_i,
   input  logic             zero_i,
   input  logic [CNT_W-1:0] t_mod_i,
   input  logic [CNT_W-1:0] t_cksre_i,
   input  logic [CNT_W-1:0] t_cksrx_i,
   input  logic [CNT_W-1:0] t_xs_i,
   output state_e           state_o,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             err_o
);
   state_e state_q, state_d;
   logic   err_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i && idle_i) state_d = ST_MR1;
         ST_MR1:  state_d = ST_W1;
         ST_W1:   if (zero_i) state_d = ST_SRE;
         ST_SRE:  state_d = ST_WSRE;
         ST_WSRE: if (zero_i) state_d = ST_CREQ;
         ST_CREQ: if (ack_i)  state_d = ST_WSRX;
         ST_WSRX: if (zero_i) state_d = ST_SRX;
         ST_SRX:  state_d = ST_WXS;
         ST_WXS:  if (zero_i) state_d = ST_MR0;
         ST_MR0:  state_d = ST_W2;
         ST_W2:   if (zero_i) state_d = ST_MR2;
         ST_MR2:  state_d = ST_W3;
         ST_W3:   if (zero_i) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      load_o     = 1'b0;
      load_val_o = t_mod_i;
      unique case (state_q)
         ST_MR1, ST_MR0, ST_MR2: load_o = 1'b1;
         ST_SRE:  begin load_o = 1'b1;  load_val_o = t_cksre_i; end
         ST_CREQ: begin load_o = ack_i; load_val_o = t_cksrx_i; end
         ST_SRX:  begin load_o = 1'b1;  load_val_o = t_xs_i;    end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= start_i && ((state_q != ST_IDLE) || !idle_i);
      end
   end

   assign state_o = state_q;
   assign err_o   = err_q;
endmodule

// File: rtl/dlloff_pin_drv.sv
module dlloff_pin_drv
   import dlloff_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned BA_W       = 3,
   parameter bit          ODT_STRICT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  state_e            state_i,
   input  logic              term_nom_en_i,
   input  logic              term_wr_en_i,
   input  logic              odt_i,
   input  logic [ADDR_W-1:0] mr1_val_i,
   input  logic [ADDR_W-1:0] mr0_val_i,
   input  logic [ADDR_W-1:0] mr2_val_i,
   output logic [1:0]        cmd_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cke_o,
   output logic              odt_o
);
   logic term_q;
   logic in_sr, post_srx, odt_post;
   cmd_e cmd;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                term_q <= 1'b0;
      else if (state_i == ST_SRE) term_q <= term_nom_en_i | term_wr_en_i;
   end

   always_comb begin
      cmd    = CMD_NOP;
      ba_o   = '0;
      addr_o = '0;
      unique case (state_i)
         ST_MR1: begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(MR1_SEL);
            addr_o = mr1_val_i | ADDR_W'(1);
         end
         ST_MR0: begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(MR0_SEL);
            addr_o = mr0_val_i;
         end
         ST_MR2: begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(MR2_SEL);
            addr_o = mr2_val_i;
         end
         ST_SRE:  cmd = CMD_SRE;
         ST_SRX:  cmd = CMD_SRX;
         default: ;
      endcase
   end
   assign cmd_o = cmd;

   assign in_sr    = (state_i == ST_SRE) || (state_i == ST_WSRE) ||
                     (state_i == ST_CREQ) || (state_i == ST_WSRX);
   assign post_srx = (state_i == ST_SRX) || (state_i == ST_WXS) ||
                     (state_i == ST_MR0) || (state_i == ST_W2) ||
                     (state_i == ST_MR2) || (state_i == ST_W3) ||
                     (state_i == ST_DONE);
   assign cke_o = !in_sr;

   generate
      if (ODT_STRICT) begin : g_odt_strict
         assign odt_post = 1'b0;
      end else begin : g_odt_free
         assign odt_post = term_q ? 1'b0 : odt_i;
      end
   endgenerate

   assign odt_o = (state_i == ST_IDLE) ? odt_i :
                  post_srx             ? odt_post : 1'b0;
endmodule

// File: rtl/dlloff_seq.sv
module dlloff_seq
   import dlloff_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned BA_W       = 3,
   parameter bit          ODT_STRICT = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              idle_i,
   input  logic [CNT_W-1:0]  t_mod_i,
   input  logic [CNT_W-1:0]  t_cksre_i,
   input  logic [CNT_W-1:0]  t_cksrx_i,
   input  logic [CNT_W-1:0]  t_xs_i,
   input  logic              term_nom_en_i,
   input  logic              term_wr_en_i,
   input  logic              odt_i,
   input  logic [ADDR_W-1:0] mr1_val_i,
   input  logic [ADDR_W-1:0] mr0_val_i,
   input  logic [ADDR_W-1:0] mr2_val_i,
   input  logic              clk_chg_ack_i,
   output logic              clk_chg_req_o,
   output logic [1:0]        cmd_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cke_o,
   output logic              odt_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   if (CNT_W < 2)  $error("CNT_W must be at least 2");
   if (ADDR_W < 4) $error("ADDR_W must be at least 4");
   if (BA_W < 2)   $error("BA_W must be at least 2");

   state_e           state;
   logic             load, zero;
   logic [CNT_W-1:0] load_val;

   dlloff_fsm #(.CNT_W(CNT_W)) fsm_i (
      .clk_i, .rst_ni, .start_i, .idle_i,
      .ack_i(clk_chg_ack_i), .zero_i(zero),
      .t_mod_i, .t_cksre_i, .t_cksrx_i, .t_xs_i,
      .state_o(state), .load_o(load), .load_val_o(load_val), .err_o(err_o)
   );

   dlloff_wait_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .zero_o(zero)
   );

   dlloff_pin_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W), .ODT_STRICT(ODT_STRICT)) drv_i (
      .clk_i, .rst_ni, .state_i(state),
      .term_nom_en_i, .term_wr_en_i, .odt_i,
      .mr1_val_i, .mr0_val_i, .mr2_val_i,
      .cmd_o, .ba_o, .addr_o, .cke_o, .odt_o
   );

   assign clk_chg_req_o = (state == ST_CREQ);
   assign busy_o        = (state != ST_IDLE);
   assign done_o        = (state == ST_DONE);
endmodule

// File: rtl/dlloff_seq_chk.sv
module dlloff_seq_chk #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned BA_W   = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              clk_chg_ack_i,
   input logic              clk_chg_req_o,
   input logic [1:0]        cmd_o,
   input logic [BA_W-1:0]   ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              cke_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o
);
   // R3
   cmd_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o != 2'd0) |=> (cmd_o == 2'd0));
   // R7
   cke_low_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_o |-> (cmd_o == 2'd0 || cmd_o == 2'd2));
   // R7
   cke_rise_srx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $rose(cke_o)) |-> (cmd_o == 2'd3));
   // R5
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_chg_req_o && !clk_chg_ack_i) |=> clk_chg_req_o);
   // R2
   mr1_dll_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_o == 2'd1 && ba_o == BA_W'(1)) |-> addr_o[0]);
   // R10
   done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (!busy_o && !done_o));
   // R11
   busy_start_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_o) |=> err_o);
endmodule

bind dlloff_seq dlloff_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
   .clk_chg_ack_i(clk_chg_ack_i), .clk_chg_req_o(clk_chg_req_o),
   .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .cke_o(cke_o),
   .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/dlloff_seq_tb.sv
`timescale 1ns/1ps
module dlloff_seq_tb_top;
   localparam int unsigned CNT_W  = 8;
   localparam int unsigned ADDR_W = 14;
   localparam int unsigned BA_W   = 3;
   localparam int NROW = 6;
   // fields: tmod, tcksre, tcksrx, txs, ack_delay, nom_en, wr_en, double_start
   localparam int VEC [NROW][8] = '{
      '{0, 0, 0, 0, 0, 0, 0, 0},
      '{3, 2, 4, 5, 1, 1, 0, 0},
      '{1, 4, 2, 3, 20, 0, 1, 1},
      '{6, 1, 0, 7, 3, 0, 0, 1},
      '{2, 5, 3, 0, 0, 1, 1, 0},
      '{12, 8, 6, 10, 2, 0, 0, 0}
   };
   localparam logic [ADDR_W-1:0] MR1V = 14'h0044;
   localparam logic [ADDR_W-1:0] MR0V = 14'h0520;
   localparam logic [ADDR_W-1:0] MR2V = 14'h0008;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, idle = 1'b1, nom = 1'b0, wr = 1'b0, odt_in = 1'b1, ack = 1'b0;
   logic [CNT_W-1:0] tmod = '0, tcksre = '0, tcksrx = '0, txs = '0;
   logic req, cke, odt, busy, done, err;
   logic [1:0] cmd;
   logic [BA_W-1:0] ba;
   logic [ADDR_W-1:0] addr;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   dlloff_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idle_i(idle),
      .t_mod_i(tmod), .t_cksre_i(tcksre), .t_cksrx_i(tcksrx), .t_xs_i(txs),
      .term_nom_en_i(nom), .term_wr_en_i(wr), .odt_i(odt_in),
      .mr1_val_i(MR1V), .mr0_val_i(MR0V), .mr2_val_i(MR2V),
      .clk_chg_ack_i(ack), .clk_chg_req_o(req), .cmd_o(cmd), .ba_o(ba),
      .addr_o(addr), .cke_o(cke), .odt_o(odt), .busy_o(busy),
      .done_o(done), .err_o(err)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_row(int r);
      int tm, se, sx, xs, ad, dbl, c_sre, c_req, c_srx, c_mr0, c_mr2, c_done;
      logic term, e_cke, e_odt;
      logic [1:0] e_cmd;
      tm = VEC[r][0]; se = VEC[r][1]; sx = VEC[r][2]; xs = VEC[r][3];
      ad = VEC[r][4]; dbl = VEC[r][7];
      term = (VEC[r][5] != 0) || (VEC[r][6] != 0);
      c_sre  = tm + 2;
      c_req  = c_sre + se + 2;
      c_srx  = c_req + ad + sx + 2;
      c_mr0  = c_srx + xs + 2;
      c_mr2  = c_mr0 + tm + 2;
      c_done = c_mr2 + tm + 2;
      @(negedge clk);
      tmod = CNT_W'(tm); tcksre = CNT_W'(se); tcksrx = CNT_W'(sx); txs = CNT_W'(xs);
      nom = VEC[r][5][0]; wr = VEC[r][6][0]; idle = 1'b1;
      start = 1'b1;
      for (int n = 0; n <= c_done + 1; n++) begin
         @(negedge clk);
         e_cmd = (n == 0 || n == c_mr0 || n == c_mr2) ? 2'd1 :
                 (n == c_sre) ? 2'd2 : (n == c_srx) ? 2'd3 : 2'd0;
         // R2 R3 R4 R6 R9: command in each cycle
         chk("R3 cmd", 32'(cmd), 32'(e_cmd));
         if (n == 0) begin
            chk("R2 mr1 ba", 32'(ba), 32'd1);
            chk("R2 mr1 addr", 32'(addr), 32'(MR1V | 14'h1));
         end
         if (n == c_mr0) begin
            chk("R9 mr0 ba", 32'(ba), 32'd0);
            chk("R9 mr0 addr", 32'(addr), 32'(MR0V));
         end
         if (n == c_mr2) begin
            chk("R9 mr2 ba", 32'(ba), 32'd2);
            chk("R9 mr2 addr", 32'(addr), 32'(MR2V));
         end
         // R7
         e_cke = !(n >= c_sre && n < c_srx);
         chk("R7 cke", 32'(cke), 32'(e_cke));
         // R8
         e_odt = (n > c_done) ? odt_in : (n >= c_srx) ? !term : 1'b0;
         chk("R8 odt", 32'(odt), 32'(e_odt));
         // R5
         chk("R5 req", 32'(req), 32'(n >= c_req && n <= c_req + ad));
         // R10
         chk("R10 done", 32'(done), 32'(n == c_done));
         chk("R10 busy", 32'(busy), 32'(n <= c_done));
         // R11
         if (n >= 1) chk("R11 err", 32'(err), 32'(dbl != 0 && n == 4));
         // drive for next cycle
         start = (dbl != 0 && n == 3);
         ack   = (n == c_req + ad);
         if (n == c_sre + 1) begin nom = ~nom; wr = ~wr; end
      end
      ack = 1'b0; nom = 1'b0; wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cmd", 32'(cmd), 32'd0);
      chk("R1 cke", 32'(cke), 32'd1);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 err", 32'(err), 32'd0);
      chk("R1 req", 32'(req), 32'd0);
      // R8 idle passthrough
      odt_in = 1'b0;
      #1 chk("R8 idle odt", 32'(odt), 32'd0);
      odt_in = 1'b1;
      #1 chk("R8 idle odt", 32'(odt), 32'd1);
      // R11: start while device not idle is dropped
      @(negedge clk);
      idle = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 not idle err", 32'(err), 32'd1);
      chk("R11 not idle busy", 32'(busy), 32'd0);
      chk("R11 not idle cmd", 32'(cmd), 32'd0);
      @(negedge clk);
      chk("R11 err pulse", 32'(err), 32'd0);
      chk("R11 still idle", 32'(busy), 32'd0);
      idle = 1'b1;
      for (int r = 0; r < NROW; r++) run_row(r);
      @(negedge clk);
      chk("R10 idle after", 32'(busy), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule